// File: doc/BRIEF.md
# Mode-banked register file

This block is the general register file of a 32-bit core whose upper registers exist in several copies, one for each processor mode. A 5-bit mode input selects which bank is visible. Registers 0 to 7 and register 15 are shared by every mode. The fast-interrupt bank has private copies of registers 8 to 14. The interrupt, supervisor, abort, undefined and system banks have private copies of registers 13 and 14 only, and use the user copies of registers 8 to 12. Mode codes that match no bank select a dummy bank. In the dummy bank, registers 8 to 14 read as zero and cannot be written.

Every copy is held in its own storage slot. The current bank, which is registered from the mode input, picks the slot for each access. Nothing has to be copied when the mode changes, yet the registers a program sees are saved and restored as if a copy had taken place. The core reads through two ports and writes through one, all in the current bank. A debugger or exception sequencer uses a side port that reads or writes any register of any mode, and the saved-status word of that mode. All read data is registered and appears one cycle after its address.

Top module: `bmr_regfile`

## Requirements
- R1: Mode codes map to banks as follows. 0x10 and 0x00 select user, 0x11 and 0x01 fast-interrupt, 0x12 and 0x02 interrupt, 0x13 and 0x03 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. Every other code selects the dummy bank.
- R2: Registers 0 to 7 and register 15 are the same storage in every mode.
- R3: The fast-interrupt bank has its own registers 8 to 14. The user values of registers 8 to 12 survive entry to and exit from that bank. All other non-dummy banks share the user registers 8 to 12.
- R4: The interrupt, supervisor, abort, undefined and system banks each have their own registers 13 and 14, separate from the user copies.
- R5: Two mode codes that map to the same bank access the same registers. Moving between them does not save or restore anything.
- R6: In the dummy bank, registers 8 to 14 read as zero. Writes to them are discarded, and no other bank's copy changes.
- R7: Read data appears on the clock edge after the address is presented. A mode change takes effect at the next edge. A read or write made in the same cycle as a mode change uses the old bank.
- R8: The side port reads (one cycle of latency) and writes any register of the bank chosen by its own mode input. When the side port and the main write port write the same register in the same cycle, the main write port wins.
- R9: The fast-interrupt, interrupt, supervisor, abort and undefined banks each hold a saved-status word, read and written through the side mode. For the user, system and dummy banks, a read returns `cur_status` as sampled at the edge, and a write is ignored.
- R10: `priv_o` is registered. It is high one edge after `mode_i` has nonzero bits [1:0], and low otherwise.
- R11: Synchronous active-high reset clears all read outputs, `st_rdata` and `priv_o`, and selects the user bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode code |
| ra_addr | input | AW | Read port A register number |
| ra_data | output | DW | Read port A data, registered |
| rb_addr | input | AW | Read port B register number |
| rb_data | output | DW | Read port B data, registered |
| wr_en | input | 1 | Main write enable (current bank) |
| wr_addr | input | AW | Main write register number |
| wr_data | input | DW | Main write data |
| sd_mode | input | 5 | Mode code selecting the side-port bank |
| sd_addr | input | AW | Side-port register number |
| sd_we | input | 1 | Side-port register write enable |
| sd_wdata | input | DW | Side-port register write data |
| sd_rdata | output | DW | Side-port register read data, registered |
| st_we | input | 1 | Saved-status write enable (side mode's bank) |
| st_wdata | input | DW | Saved-status write data |
| cur_status | input | DW | Current status word, returned for banks with no saved-status word |
| st_rdata | output | DW | Saved-status read data, registered |
| priv_o | output | 1 | Privileged-mode indication |

## Verification
A main-port write can land in the same cycle as a mode change, and a side-port write can land in the same cycle as a main-port write. The bench writes register 13 while switching from user to supervisor. It then reads both banks and expects the new value only in the user copy, while the supervisor copy keeps its value. The bench also issues a main write and a side write to shared register 3 in one cycle, and expects the main value to win. In a second paired write, to register 8 in the user and fast-interrupt banks, it expects both values to land.

// File: rtl/bmr_pkg.sv
`timescale 1ns/1ps
package bmr_pkg;
  localparam int MODE_W    = 5;
  localparam int BANK_W    = 3;
  localparam int NUM_BANKS = 8;
  localparam int FIQ_FIRST = 8;   // first register private to the fast-interrupt bank
  localparam int SP_REG    = 13;  // first register private to every non-user bank
  localparam int PC_REG    = 15;
  localparam int NSAVED    = 5;

  typedef enum logic [BANK_W-1:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_DUM
  } bank_e;

  function automatic logic has_saved(input logic [BANK_W-1:0] b);
    return (b >= BK_FIQ) && (b <= BK_UND);
  endfunction

  function automatic logic [BANK_W-1:0] saved_slot(input logic [BANK_W-1:0] b);
    return b - 3'd1;
  endfunction
endpackage

// File: rtl/bmr_mode_map.sv
`timescale 1ns/1ps
module bmr_mode_map import bmr_pkg::*; (
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);
  always_comb begin
    case (mode)
      5'h00, 5'h10: bank = BK_USR;
      5'h01, 5'h11: bank = BK_FIQ;
      5'h02, 5'h12: bank = BK_IRQ;
      5'h03, 5'h13: bank = BK_SVC;
      5'h17:        bank = BK_ABT;
      5'h1B:        bank = BK_UND;
      5'h1F:        bank = BK_SYS;
      default:      bank = BK_DUM;
    endcase
  end
endmodule

// File: rtl/bmr_store.sv
`timescale 1ns/1ps
module bmr_store import bmr_pkg::*; #(
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int NRP = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wa_en,
  input  logic [BANK_W-1:0]          wa_bank,
  input  logic [AW-1:0]              wa_addr,
  input  logic [DW-1:0]              wa_data,
  input  logic                       wb_en,
  input  logic [BANK_W-1:0]          wb_bank,
  input  logic [AW-1:0]              wb_addr,
  input  logic [DW-1:0]              wb_data,
  input  logic [NRP-1:0][BANK_W-1:0] rd_bank,
  input  logic [NRP-1:0][AW-1:0]     rd_addr,
  output logic [NRP-1:0][DW-1:0]     rd_data
);
  // Slot layout: shared low registers, PC, user 8..12, fast-interrupt 8..12,
  // then one pair (13,14) per bank except the dummy bank.
  localparam int SLOT_PC   = FIQ_FIRST;
  localparam int SLOT_USR  = SLOT_PC + 1;
  localparam int SLOT_FIQ  = SLOT_USR + (SP_REG - FIQ_FIRST);
  localparam int SLOT_PAIR = SLOT_FIQ + (SP_REG - FIQ_FIRST);
  localparam int NSLOT     = SLOT_PAIR + 2 * (NUM_BANKS - 1);
  localparam int SW        = $clog2(NSLOT);

  logic [DW-1:0] mem [NSLOT];

  function automatic logic [SW:0] slot_of(input logic [BANK_W-1:0] b, input logic [AW-1:0] r);
    int ri;
    int s;
    logic ok;
    ri = int'(r);
    s  = 0;
    ok = 1'b1;
    if (ri < FIQ_FIRST)     s = ri;
    else if (ri == PC_REG)  s = SLOT_PC;
    else if (b == BK_DUM)   ok = 1'b0;
    else if (ri < SP_REG)   s = ((b == BK_FIQ) ? SLOT_FIQ : SLOT_USR) + ri - FIQ_FIRST;
    else                    s = SLOT_PAIR + 2 * int'(b) + ri - SP_REG;
    return {ok, s[SW-1:0]};
  endfunction

  logic [SW:0] wa_slot, wb_slot;
  assign wa_slot = slot_of(wa_bank, wa_addr);
  assign wb_slot = slot_of(wb_bank, wb_addr);

  // Side write first, main write last: the main port wins a shared slot.
  always_ff @(posedge clk) begin
    if (wb_en && wb_slot[SW]) mem[wb_slot[SW-1:0]] <= wb_data;
    if (wa_en && wa_slot[SW]) mem[wa_slot[SW-1:0]] <= wa_data;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    logic [SW:0]   sl;
    logic [DW-1:0] q;
    assign sl = slot_of(rd_bank[p], rd_addr[p]);
    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (sl[SW]) q <= mem[sl[SW-1:0]];
      else             q <= '0;
    end
    assign rd_data[p] = q;
  end
endmodule

// File: rtl/bmr_saved_status.sv
`timescale 1ns/1ps
module bmr_saved_status import bmr_pkg::*; #(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     cur,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0]     held [NSAVED];
  logic              ok;
  logic [BANK_W-1:0] idx;

  assign ok  = has_saved(bank);
  assign idx = saved_slot(bank);

  always_ff @(posedge clk) begin
    if (we && ok) held[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (ok) rdata <= held[idx];
    else         rdata <= cur;
  end
endmodule

// File: rtl/bmr_regfile.sv
`timescale 1ns/1ps
module bmr_regfile import bmr_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     ra_addr,
  output logic [DW-1:0]     ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DW-1:0]     rb_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [MODE_W-1:0] sd_mode,
  input  logic [AW-1:0]     sd_addr,
  input  logic              sd_we,
  input  logic [DW-1:0]     sd_wdata,
  output logic [DW-1:0]     sd_rdata,
  input  logic              st_we,
  input  logic [DW-1:0]     st_wdata,
  input  logic [DW-1:0]     cur_status,
  output logic [DW-1:0]     st_rdata,
  output logic              priv_o
);
  localparam int NRP = 3;

  bank_e             cur_bank_nxt, sd_bank;
  logic [BANK_W-1:0] bank_q;
  logic              priv_q;

  bmr_mode_map u_cur_map (.mode(mode_i),  .bank(cur_bank_nxt));
  bmr_mode_map u_sd_map  (.mode(sd_mode), .bank(sd_bank));

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= BK_USR;
      priv_q <= 1'b0;
    end else begin
      bank_q <= cur_bank_nxt;
      priv_q <= |mode_i[1:0];
    end
  end
  assign priv_o = priv_q;

  logic [NRP-1:0][BANK_W-1:0] rd_bank;
  logic [NRP-1:0][AW-1:0]     rd_addr;
  logic [NRP-1:0][DW-1:0]     rd_data;

  assign rd_bank = {sd_bank, bank_q, bank_q};
  assign rd_addr = {sd_addr, rb_addr, ra_addr};

  bmr_store #(.DW(DW), .AW(AW), .NRP(NRP)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wr_en),
    .wa_bank (bank_q),
    .wa_addr (wr_addr),
    .wa_data (wr_data),
    .wb_en   (sd_we),
    .wb_bank (sd_bank),
    .wb_addr (sd_addr),
    .wb_data (sd_wdata),
    .rd_bank (rd_bank),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign ra_data  = rd_data[0];
  assign rb_data  = rd_data[1];
  assign sd_rdata = rd_data[2];

  bmr_saved_status #(.DW(DW)) u_status (
    .clk   (clk),
    .rst   (rst),
    .bank  (sd_bank),
    .we    (st_we),
    .wdata (st_wdata),
    .cur   (cur_status),
    .rdata (st_rdata)
  );
endmodule

// File: rtl/bmr_regfile_chk.sv
`timescale 1ns/1ps
module bmr_regfile_chk import bmr_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_i,
  input logic [AW-1:0]     ra_addr,
  input logic [DW-1:0]     ra_data,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [MODE_W-1:0] sd_mode,
  input logic              sd_we,
  input logic [DW-1:0]     st_rdata,
  input logic [DW-1:0]     cur_status,
  input logic              priv_o,
  input logic [BANK_W-1:0] cur_bank
);
  logic live = 1'b0;
  always_ff @(posedge clk) live <= !rst;

  // R10: privilege follows the low mode bits one edge later
  a_r10_priv_follows_mode: assert property (@(posedge clk) disable iff (rst)
    live |-> (priv_o == (|$past(mode_i[1:0]))));

  // R6: dummy bank hides registers 8 to 14
  a_r6_dummy_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (cur_bank == BK_DUM && int'(ra_addr) >= FIQ_FIRST && int'(ra_addr) < PC_REG)
    |=> (ra_data == '0));

  // R8: a main write to a shared register is what a later read returns
  a_r8_main_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < FIQ_FIRST ##1 (!wr_en && !sd_we && ra_addr == $past(wr_addr)))
    |=> (ra_data == $past(wr_data, 2)));

  // R9: user, system and a dummy code have no saved-status word
  a_r9_status_passthrough: assert property (@(posedge clk) disable iff (rst)
    (sd_mode == 5'h10 || sd_mode == 5'h1F || sd_mode == 5'h04)
    |=> (st_rdata == $past(cur_status)));
endmodule

bind bmr_regfile bmr_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .ra_addr    (ra_addr),
  .ra_data    (ra_data),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .sd_mode    (sd_mode),
  .sd_we      (sd_we),
  .st_rdata   (st_rdata),
  .cur_status (cur_status),
  .priv_o     (priv_o),
  .cur_bank   (bank_q)
);

// File: tb/sim_bmr_regfile.sv
`timescale 1ns/1ps
module sim_bmr_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'h13;
  logic [3:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0, sd_addr = '0;
  logic        wr_en = 1'b0, sd_we = 1'b0, st_we = 1'b0;
  logic [31:0] wr_data = '0, sd_wdata = '0, st_wdata = '0, cur_status = '0;
  logic [4:0]  sd_mode = 5'h10;
  logic [31:0] ra_data, rb_data, sd_rdata, st_rdata;
  logic        priv_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bmr_regfile u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sd_mode(sd_mode), .sd_addr(sd_addr), .sd_we(sd_we), .sd_wdata(sd_wdata),
    .sd_rdata(sd_rdata), .st_we(st_we), .st_wdata(st_wdata),
    .cur_status(cur_status), .st_rdata(st_rdata), .priv_o(priv_o)
  );

  typedef struct packed { logic [4:0] mode; logic [31:0] r13; } vec_t;
  localparam vec_t VEC [0:14] = '{
    '{5'h10, 32'hD000_0010}, '{5'h00, 32'hD000_0010},
    '{5'h11, 32'hD000_0011}, '{5'h01, 32'hD000_0011},
    '{5'h12, 32'hD000_0012}, '{5'h02, 32'hD000_0012},
    '{5'h13, 32'hD000_0013}, '{5'h03, 32'hD000_0013},
    '{5'h17, 32'hD000_0017}, '{5'h1B, 32'hD000_001B},
    '{5'h1F, 32'hD000_001F}, '{5'h04, 32'h0},
    '{5'h16, 32'h0},         '{5'h1E, 32'h0},
    '{5'h08, 32'h0}
  };
  localparam logic [4:0] CANON [0:6] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick;
    wr_en = 1'b0;
  endtask

  task automatic side_wr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
    sd_we = 1'b1; sd_mode = m; sd_addr = a; sd_wdata = d;
    tick;
    sd_we = 1'b0;
  endtask

  task automatic go_mode(input logic [4:0] m);
    mode_i = m;
    tick;
  endtask

  task automatic rd(input logic [3:0] a);
    ra_addr = a;
    tick;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    // R11: outputs cleared by reset, before any edge with reset low
    chk("R11", "ra_data after reset", ra_data, 32'h0);
    chk("R11", "st_rdata after reset", st_rdata, 32'h0);
    chk("R11", "priv_o after reset", {31'h0, priv_o}, 32'h0);

    go_mode(5'h10);
    for (int i = 0; i < 7; i++) begin
      side_wr(CANON[i], 4'd13, 32'hD000_0000 | 32'(CANON[i]));
      side_wr(CANON[i], 4'd14, 32'hE000_0000 | 32'(CANON[i]));
    end

    // R1 R4 R5 R6 R10: walk the vector table
    for (int i = 0; i < 15; i++) begin
      logic [31:0] e14;
      e14 = (VEC[i].r13 == 32'h0) ? 32'h0 : {4'hE, VEC[i].r13[27:0]};
      mode_i = VEC[i].mode; ra_addr = 4'd13; rb_addr = 4'd14;
      tick; tick;
      chk("R1/R4/R5/R6", "r13 in table mode", ra_data, VEC[i].r13);
      chk("R4/R5/R6", "r14 in table mode", rb_data, e14);
      chk("R10", "priv_o", {31'h0, priv_o}, {31'h0, |VEC[i].mode[1:0]});
    end

    // R8: side read of another mode
    sd_mode = 5'h1B; sd_addr = 4'd13; tick;
    chk("R8", "side read undefined r13", sd_rdata, 32'hD000_001B);

    // R2: shared registers
    go_mode(5'h10);
    wr(4'd5, 32'h5555_0005);
    wr(4'd15, 32'hF0F0_000F);
    go_mode(5'h11);
    ra_addr = 4'd5; rb_addr = 4'd15; tick;
    chk("R2", "r5 seen from fast-interrupt", ra_data, 32'h5555_0005);
    chk("R2", "r15 seen from fast-interrupt", rb_data, 32'hF0F0_000F);

    // R3: fast-interrupt private 8..12
    go_mode(5'h10);
    wr(4'd9, 32'h1111_0009);
    wr(4'd10, 32'hA0A0_000A);
    go_mode(5'h11);
    wr(4'd9, 32'h2222_0009);
    rd(4'd9);
    chk("R3", "fast-interrupt r9", ra_data, 32'h2222_0009);
    go_mode(5'h10);
    rd(4'd9);
    chk("R3", "user r9 restored", ra_data, 32'h1111_0009);
    go_mode(5'h12);
    rd(4'd9);
    chk("R3", "interrupt shares user r9", ra_data, 32'h1111_0009);
    sd_mode = 5'h11; sd_addr = 4'd9; tick;
    chk("R3", "side read fast-interrupt r9", sd_rdata, 32'h2222_0009);

    // R6: dummy writes discarded
    go_mode(5'h04);
    wr(4'd10, 32'h0BAD_0BAD);
    rd(4'd10);
    chk("R6", "dummy r10", ra_data, 32'h0);
    go_mode(5'h10);
    rd(4'd10);
    chk("R6", "user r10 untouched", ra_data, 32'hA0A0_000A);

    // R7: write in the mode-change cycle goes to the old bank
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h7777_000D; mode_i = 5'h13;
    tick;
    wr_en = 1'b0;
    rd(4'd13);
    chk("R7", "supervisor r13 kept", ra_data, 32'hD000_0013);
    go_mode(5'h10);
    rd(4'd13);
    chk("R7", "user r13 took write", ra_data, 32'h7777_000D);
    mode_i = 5'h11; ra_addr = 4'd13; tick;
    chk("R7", "read in change cycle uses old bank", ra_data, 32'h7777_000D);
    tick;
    chk("R7", "read after change uses new bank", ra_data, 32'hD000_0011);

    // R8: collisions
    go_mode(5'h10);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'hAAAA_0003;
    sd_we = 1'b1; sd_mode = 5'h11; sd_addr = 4'd3; sd_wdata = 32'hBBBB_0003;
    tick;
    wr_en = 1'b0; sd_we = 1'b0;
    rd(4'd3);
    chk("R8", "main wins shared r3", ra_data, 32'hAAAA_0003);
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'h8001_0008;
    sd_we = 1'b1; sd_mode = 5'h11; sd_addr = 4'd8; sd_wdata = 32'h8002_0008;
    tick;
    wr_en = 1'b0; sd_we = 1'b0;
    ra_addr = 4'd8; tick;
    chk("R8", "user r8 from main", ra_data, 32'h8001_0008);
    chk("R8", "fast-interrupt r8 from side", sd_rdata, 32'h8002_0008);

    // R9: saved-status words
    cur_status = 32'hC5C5_0000;
    st_we = 1'b1; sd_mode = 5'h12; st_wdata = 32'h12AB_0000; tick;
    sd_mode = 5'h13; st_wdata = 32'h13AB_0000; tick;
    sd_mode = 5'h10; st_wdata = 32'hDEAD_0000; tick;
    sd_mode = 5'h05; st_wdata = 32'hDEAD_0005; tick;
    st_we = 1'b0;
    sd_mode = 5'h12; tick;
    chk("R9", "interrupt saved status", st_rdata, 32'h12AB_0000);
    sd_mode = 5'h13; tick;
    chk("R9", "supervisor saved status", st_rdata, 32'h13AB_0000);
    sd_mode = 5'h10; tick;
    chk("R9", "user returns current status", st_rdata, 32'hC5C5_0000);
    cur_status = 32'h5C5C_0001; sd_mode = 5'h1F; tick;
    chk("R9", "system returns current status", st_rdata, 32'h5C5C_0001);
    sd_mode = 5'h05; tick;
    chk("R9", "dummy returns current status", st_rdata, 32'h5C5C_0001);

    // R11: reset in mid-run
    go_mode(5'h13);
    rst = 1'b1; tick; rst = 1'b0;
    chk("R11", "ra_data cleared", ra_data, 32'h0);
    chk("R11", "sd_rdata cleared", sd_rdata, 32'h0);
    chk("R11", "priv_o cleared", {31'h0, priv_o}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule